// File: doc/BRIEF.md
# Binary-Weighted Time-Pulse Generator

This block turns a small unsigned number into time. On an accepted start request it captures the number. It then drives one enable line whose total high time equals that number of reference-clock periods. A downstream integrator, such as a switched current source charging a capacitor, can use this enable as a time-domain DAC.

The timing comes from a chain of divide-by-two stages clocked by the reference clock. Each stage's phase is twice as long as the one below it. The output walks through one window per bit, from the least significant bit up. Window k lasts 2^k periods and is passed to the output only when bit k of the captured value is set. A window for a cleared bit still uses its full time slot with the output low. The frame length therefore does not depend on the value.

A busy flag covers the whole frame. A single-cycle done strobe follows it. The output is a register, so it only changes on reference-clock edges.

Top module: `time_pulse_gen`

## Requirements
- R1: While reset is high, and on the first clock after it is released, `pulse_out`, `busy` and `done` are low, and a start request is not accepted.
- R2: For every accepted start, the number of clock cycles in which `pulse_out` is high equals the captured value.
- R3: Counting the cycle right after the accepting edge as slot 0, slot s (1 ≤ s ≤ 2^NBITS−1) carries `pulse_out` equal to bit k of the captured value, where k is the position of the highest set bit of s. Windows therefore run LSB first, and window k lasts 2^k cycles.
- R4: A cleared bit keeps its window length with the output low. The frame always spans 2^NBITS−1 pulse slots, whatever the value, including 0 and all ones.
- R5: `value_in` is sampled only at the edge that accepts a start. Changes on it during the frame have no effect on `pulse_out`.
- R6: A start request seen while `busy` is high is ignored. The running frame keeps its length and its output pattern.
- R7: `busy` rises on the edge that accepts a start and stays high for exactly 2^NBITS cycles (slots 0 to 2^NBITS−1). `done` is high for exactly one cycle, in slot 2^NBITS, when `busy` has just fallen.
- R8: `pulse_out` is never high while `busy` is low.
- R9: A start request present in the `done` cycle is accepted, so frames can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one period is one unit of high time |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a frame, accepted when not busy |
| value_in | input | NBITS | Unsigned value to convert, captured on acceptance |
| pulse_out | output | 1 | Registered gated window train |
| busy | output | 1 | High for the duration of a frame |
| done | output | 1 | One-cycle strobe after the frame ends |

## Verification
The checker takes for granted that `start_req` and `value_in` are synchronous to `clk` and settle before each rising edge. It takes the high-time total and the frame length on trust only as counted at the ports, not from internal state.

The stimulus changes inputs only on falling edges. It always changes `value_in` right after acceptance. In some frames it raises `start_req` in the middle, so that both the hold rule and the ignore rule are exercised under inputs that stay within those assumptions.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Frame controller phases
  typedef enum logic [1:0] {
    FRM_IDLE = 2'd0,
    FRM_RUN  = 2'd1,
    FRM_TAIL = 2'd2
  } frame_state_e;

endpackage

// File: rtl/tpg_halving_chain.sv
// Chain of divide-by-two stages. Stage k toggles when every stage below it
// is high, so stage k's phase is twice as long as stage k-1's. Loading
// the chain puts it at position 1 (only stage 0 set).
module tpg_halving_chain #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [NBITS-1:0] stage_q,
  output logic             at_end
);

  logic [NBITS:0] carry_in;

  assign carry_in[0] = step;

  for (genvar k = 0; k < NBITS; k++) begin : g_stage
    assign carry_in[k+1] = carry_in[k] & stage_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[k] <= 1'b0;
      end else if (load) begin
        stage_q[k] <= (k == 0);
      end else if (carry_in[k]) begin
        stage_q[k] <= ~stage_q[k];
      end
    end
  end

  assign at_end = &stage_q;

endmodule

// File: rtl/tpg_window_select.sv
// Picks the active bit window from the chain position (highest set stage)
// and gates it with the captured value.
module tpg_window_select #(
  parameter int NBITS = 4
) (
  input  logic [NBITS-1:0] stage_q,
  input  logic [NBITS-1:0] value_q,
  output logic [NBITS-1:0] window_oh,
  output logic             gate_on
);

  logic [NBITS-1:0] upper_any;

  assign upper_any[NBITS-1] = 1'b0;

  for (genvar k = 0; k < NBITS - 1; k++) begin : g_upper
    assign upper_any[k] = upper_any[k+1] | stage_q[k+1];
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_win
    assign window_oh[k] = stage_q[k] & ~upper_any[k];
  end

  assign gate_on = |(window_oh & value_q);

endmodule

// File: rtl/tpg_frame_ctrl.sv
// Frame sequencer: accepts a start when idle, latches the value, steps the
// halving chain through all windows, then spends one tail cycle before
// returning to idle with a done strobe.
module tpg_frame_ctrl
  import tpg_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [NBITS-1:0] value_in,
  input  logic             chain_end,
  output logic             chain_load,
  output logic             chain_step,
  output logic             running,
  output logic [NBITS-1:0] value_q,
  output logic             busy_q,
  output logic             done_q
);

  frame_state_e state_q, state_d;
  logic         accept;

  assign accept     = (state_q == FRM_IDLE) && start_req;
  assign chain_load = accept;
  assign chain_step = (state_q == FRM_RUN) && !chain_end;
  assign running    = (state_q == FRM_RUN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      FRM_IDLE: if (start_req) state_d = FRM_RUN;
      FRM_RUN:  if (chain_end) state_d = FRM_TAIL;
      FRM_TAIL: state_d = FRM_IDLE;
      default:  state_d = FRM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FRM_IDLE;
      value_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == FRM_TAIL);
      if (accept) begin
        value_q <= value_in;
        busy_q  <= 1'b1;
      end else if (state_q == FRM_TAIL) begin
        busy_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/time_pulse_gen.sv
module time_pulse_gen #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [NBITS-1:0] value_in,
  output logic             pulse_out,
  output logic             busy,
  output logic             done
);

  logic             chain_load;
  logic             chain_step;
  logic             chain_end;
  logic             running;
  logic [NBITS-1:0] stage_q;
  logic [NBITS-1:0] value_q;
  logic [NBITS-1:0] window_oh;
  logic             gate_on;
  logic             pulse_q;

  tpg_frame_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .value_in   (value_in),
    .chain_end  (chain_end),
    .chain_load (chain_load),
    .chain_step (chain_step),
    .running    (running),
    .value_q    (value_q),
    .busy_q     (busy),
    .done_q     (done)
  );

  tpg_halving_chain #(.NBITS(NBITS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .load    (chain_load),
    .step    (chain_step),
    .stage_q (stage_q),
    .at_end  (chain_end)
  );

  tpg_window_select #(.NBITS(NBITS)) u_sel (
    .stage_q   (stage_q),
    .value_q   (value_q),
    .window_oh (window_oh),
    .gate_on   (gate_on)
  );

  // Registered output: changes only on reference clock edges
  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= running & gate_on;
  end

  assign pulse_out = pulse_q;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int NBITS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_req,
  input logic [NBITS-1:0] value_in,
  input logic             pulse_out,
  input logic             busy,
  input logic             done
);

  localparam logic [NBITS:0] FRAME_LEN = (NBITS+1)'(1) << NBITS;

  logic [NBITS:0]   run_q;
  logic [NBITS-1:0] cap_q;
  logic [NBITS-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      cap_q <= '0;
      hi_q  <= '0;
    end else begin
      run_q <= busy ? run_q + 1'b1 : '0;
      if (start_req && !busy) begin
        cap_q <= value_in;
        hi_q  <= '0;
      end else if (pulse_out) begin
        hi_q  <= hi_q + 1'b1;
      end
    end
  end

  AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> busy); // R9

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == FRAME_LEN)); // R6

  AST_HIGH_TIME: assert property (@(posedge clk) disable iff (rst)
    done |-> (hi_q == cap_q)); // R2

endmodule

bind time_pulse_gen tpg_checker #(.NBITS(NBITS)) u_tpg_chk (
  .clk       (clk),
  .rst       (rst),
  .start_req (start_req),
  .value_in  (value_in),
  .pulse_out (pulse_out),
  .busy      (busy),
  .done      (done)
);

// File: tb/time_pulse_gen_test.sv
`timescale 1ns/1ps
module time_pulse_gen_test;

  localparam int N    = 4;
  localparam int SLOTS = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_req = 1'b0;
  logic [N-1:0] value_in = '0;
  logic         pulse_out, busy, done;

  int n_checks = 0;
  int n_fail   = 0;

  time_pulse_gen #(.NBITS(N)) uut (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .value_in  (value_in),
    .pulse_out (pulse_out),
    .busy      (busy),
    .done      (done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int top_bit(input int s);
    int m = 0;
    for (int i = 0; i < 31; i++) if ((s >> i) & 1) m = i;
    return m;
  endfunction

  // Caller stands at a falling edge. Slot s is the cycle s after the
  // accepting edge. Returns at the falling edge of slot SLOTS (done cycle).
  task automatic run_frame(input logic [N-1:0] v, input bit meddle,
                           input bit tail, input string tag);
    logic [SLOTS:0] obs_p = '0, exp_p = '0;
    logic [SLOTS:0] obs_b = '0, exp_b = '0;
    logic [SLOTS:0] obs_d = '0, exp_d = '0;
    int hi = 0;
    value_in  = v;
    start_req = 1'b1;
    for (int s = 0; s <= SLOTS; s++) begin
      @(negedge clk);
      obs_p[s] = pulse_out;
      obs_b[s] = busy;
      obs_d[s] = done;
      exp_b[s] = (s < SLOTS);
      exp_d[s] = (s == SLOTS);
      exp_p[s] = (s >= 1 && s < SLOTS) ? v[top_bit(s)] : 1'b0;
      if (pulse_out) hi++;
      if (s == 0) begin
        start_req = 1'b0;
        value_in  = ~v;          // R5: change after capture
      end
      if (meddle && s == 5) start_req = 1'b1;   // R6
      if (meddle && s == 7) start_req = 1'b0;
    end
    check(hi == int'(v), "R2", {tag, " high time"}, hi, v);
    check(obs_p == exp_p, meddle ? "R6" : "R3", {tag, " window pattern"},
          obs_p, exp_p);
    check(obs_b == exp_b, "R4", {tag, " busy span"}, obs_b, exp_b);
    check(obs_d == exp_d, "R7", {tag, " done strobe"}, obs_d, exp_d);
    if (tail) begin
      @(negedge clk);
      check({pulse_out, busy, done} == 3'b000, "R8", {tag, " idle after done"},
            {pulse_out, busy, done}, 0);
    end
  endtask

  task automatic test_reset();
    value_in  = '1;
    start_req = 1'b1;
    repeat (3) @(negedge clk);
    check({pulse_out, busy, done} == 3'b000, "R1", "outputs in reset",
          {pulse_out, busy, done}, 0);
    start_req = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check({pulse_out, busy, done} == 3'b000, "R1", "first cycle after reset",
          {pulse_out, busy, done}, 0);
  endtask

  task automatic test_values();
    run_frame(4'd0,  1'b0, 1'b1, "zero");       // R4 all windows blank
    run_frame(4'd15, 1'b0, 1'b1, "all ones");
    run_frame(4'b1010, 1'b0, 1'b1, "0xA");      // R3
    run_frame(4'b0101, 1'b0, 1'b1, "0x5");
    run_frame(4'd1,  1'b0, 1'b1, "lsb only");
    run_frame(4'd8,  1'b0, 1'b1, "msb only");
  endtask

  task automatic test_busy_start();
    run_frame(4'd6, 1'b1, 1'b1, "start while busy");  // R6
  endtask

  task automatic test_back_to_back();
    run_frame(4'd9, 1'b0, 1'b0, "b2b first");
    run_frame(4'd3, 1'b0, 1'b1, "b2b second (R9)");
  endtask

  initial begin
    test_reset();
    test_values();
    test_busy_start();
    test_back_to_back();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule